// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor

This block is a small stored-program processor built around one 16-bit accumulator (AC) and a one-bit carry latch (E). Program and data share an internal memory of 4096 words of 16 bits. Every instruction is one word and runs in three clock cycles: fetch, operand-address resolution and execute. A taken interrupt adds one more cycle.

Bit 15 of an instruction selects indirect addressing, and bits 14-12 hold the opcode. For opcodes 0 to 6, bits 11-0 are a memory address. Opcode 7 picks one of two one-hot control fields in bits 11-0. With bit 15 clear, the field drives an accumulator or carry operation. With bit 15 set, it drives a character input/output or interrupt-control operation. The processor has an 8-bit input character port with a ready flag, an 8-bit output character port with a ready flag, an interrupt-enable latch and a run/halt state.

The memory is filled through a load port while reset is held. After reset is released, execution starts at address 0x010 and continues until a halt instruction.

Top module: `cpu_acc`

## Requirements
- R1: While reset is held, PC is 0x010, AC is 0, E is 0, the core is running (not halted), interrupts are disabled, the input flag is 0 and the output flag is 1.
- R2: Opcode 0 (AND) and opcode 2 (LDA) set AC to AC AND M and to M respectively, and leave E unchanged. Opcode 1 (ADD) sets AC to the low 16 bits of AC+M and sets E to the carry out.
- R3: When bit 15 is set and the opcode is 0 to 6, the effective address is the low 12 bits of the word stored at bits 11-0. When bit 15 is clear, the effective address is bits 11-0 themselves.
- R4: Opcode 3 (STA) writes AC to the effective address. Opcode 5 (BSA) writes the address of the next instruction to the effective address and continues at the effective address plus one.
- R5: Opcode 6 (ISZ) writes the word at the effective address plus one back to memory, and skips the next instruction when that result is zero.
- R6: Opcode 4 (BUN) continues execution at the effective address.
- R7: In the register group (opcode 7, bit 15 clear), the field values have these effects: 0x800 clears AC, 0x400 clears E, 0x200 inverts AC, 0x100 inverts E, and 0x020 adds 1 to AC without touching E.
- R8: Field 0x080 rotates the 17-bit value {E,AC} right, so AC[0] moves into E. Field 0x040 rotates it left, so AC[15] moves into E.
- R9: A skip adds one more to the 12-bit PC, which wraps from 0xFFF to 0x000. The skip conditions are: 0x010 when AC is nonzero with bit 15 clear, 0x008 when AC bit 15 is set, 0x004 when AC is zero, and 0x002 when E is zero.
- R10: Field 0x001 halts the core. Once halted, the core stays halted and PC stays frozen until reset.
- R11: In the I/O group (opcode 7, bit 15 set), 0x800 replaces AC[7:0] with the input character, keeps AC[15:8] and clears the input flag. 0x400 drives AC[7:0] to the output port and clears the output flag. A one-cycle input or output strobe sets the matching flag on the next cycle.
- R12: I/O field 0x200 skips when the input flag is set, and 0x100 skips when the output flag is set.
- R13: I/O field 0x080 enables interrupts and 0x040 disables them. After an instruction, if interrupts are enabled and either flag is set, the core writes PC to address 0, sets PC to 1 and disables interrupts.
- R14: The load port writes memory only while reset is held. While running, load-port writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; memory loading happens while low |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | 12 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| in_char | input | 8 | Input character |
| in_strobe | input | 1 | One-cycle pulse: a new input character is present |
| out_strobe | input | 1 | One-cycle pulse: the output character was consumed |
| out_char | output | 8 | Last character written out |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| e | output | 1 | Carry latch |
| halted | output | 1 | Core is halted |
| ie | output | 1 | Interrupt-enable latch |
| in_flag | output | 1 | Input-ready flag |
| out_flag | output | 1 | Output-ready flag |

## Verification
The data operations are run on operand pairs chosen so that each result separates the intended operation from its neighbours: overlapping bit masks for AND, an all-ones accumulator for carry generation, and a preset carry to show which operations keep E and which rewrite it. Each skip test is run once with a value that meets its condition and once with a value that just misses it (positive against zero, and sign set against the largest positive). The final PC then shows whether exactly one word was skipped. Short directed programs cover memory write-back (STA, BSA, ISZ), PC wrap-around, character handshakes driven by flag polling, and an interrupt raised from an idle loop. The stored return address and the final interrupt-enable value tell a taken interrupt apart from one that was blocked.

// File: rtl/cpu_acc_pkg.sv
package cpu_acc_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_INTR   = 3'd3,
        ST_HALT   = 3'd4
    } cpu_state_e;

    localparam logic [2:0] OP_AND = 3'd0;
    localparam logic [2:0] OP_ADD = 3'd1;
    localparam logic [2:0] OP_LDA = 3'd2;
    localparam logic [2:0] OP_STA = 3'd3;
    localparam logic [2:0] OP_BUN = 3'd4;
    localparam logic [2:0] OP_BSA = 3'd5;
    localparam logic [2:0] OP_ISZ = 3'd6;
    localparam logic [2:0] OP_GRP = 3'd7;

    // register-group field bits
    localparam int G_CLRA = 11;
    localparam int G_CLRE = 10;
    localparam int G_INVA = 9;
    localparam int G_INVE = 8;
    localparam int G_ROTR = 7;
    localparam int G_ROTL = 6;
    localparam int G_INCA = 5;
    localparam int G_SPOS = 4;
    localparam int G_SNEG = 3;
    localparam int G_SZRA = 2;
    localparam int G_SZRE = 1;
    localparam int G_STOP = 0;

    // I/O-group field bits
    localparam int X_GETC = 11;
    localparam int X_PUTC = 10;
    localparam int X_SKIN = 9;
    localparam int X_SKOUT = 8;
    localparam int X_IEON = 7;
    localparam int X_IEOFF = 6;

endpackage

// File: rtl/cpu_acc_mem.sv
module cpu_acc_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/cpu_acc_grp.sv
module cpu_acc_grp
    import cpu_acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter int FLD_W  = 12
) (
    input  logic              io_sel,
    input  logic [FLD_W-1:0]  fld,
    input  logic [DATA_W-1:0] ac,
    input  logic              e,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_flag,
    input  logic              out_flag,
    output logic [DATA_W-1:0] ac_n,
    output logic              e_n,
    output logic              skip,
    output logic              stop,
    output logic              take_in,
    output logic              put_out,
    output logic              ie_on,
    output logic              ie_off
);
    always_comb begin
        ac_n    = ac;
        e_n     = e;
        skip    = 1'b0;
        stop    = 1'b0;
        take_in = 1'b0;
        put_out = 1'b0;
        ie_on   = 1'b0;
        ie_off  = 1'b0;
        if (io_sel) begin
            if (fld[X_GETC]) begin
                ac_n    = {ac[DATA_W-1:CHAR_W], in_char};
                take_in = 1'b1;
            end else if (fld[X_PUTC]) begin
                put_out = 1'b1;
            end else if (fld[X_SKIN]) begin
                skip = in_flag;
            end else if (fld[X_SKOUT]) begin
                skip = out_flag;
            end else if (fld[X_IEON]) begin
                ie_on = 1'b1;
            end else if (fld[X_IEOFF]) begin
                ie_off = 1'b1;
            end
        end else begin
            if (fld[G_CLRA]) begin
                ac_n = '0;
            end else if (fld[G_CLRE]) begin
                e_n = 1'b0;
            end else if (fld[G_INVA]) begin
                ac_n = ~ac;
            end else if (fld[G_INVE]) begin
                e_n = ~e;
            end else if (fld[G_ROTR]) begin
                ac_n = {e, ac[DATA_W-1:1]};
                e_n  = ac[0];
            end else if (fld[G_ROTL]) begin
                ac_n = {ac[DATA_W-2:0], e};
                e_n  = ac[DATA_W-1];
            end else if (fld[G_INCA]) begin
                ac_n = ac + DATA_W'(1);
            end else if (fld[G_SPOS]) begin
                skip = !ac[DATA_W-1] && (ac != '0);
            end else if (fld[G_SNEG]) begin
                skip = ac[DATA_W-1];
            end else if (fld[G_SZRA]) begin
                skip = (ac == '0);
            end else if (fld[G_SZRE]) begin
                skip = !e;
            end else if (fld[G_STOP]) begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_acc_ctrl.sv
module cpu_acc_ctrl
    import cpu_acc_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              DATA_W   = 16,
    parameter int              CHAR_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_strobe,
    input  logic              out_strobe,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ac,
    output logic              e,
    output logic              ie,
    output logic              halted,
    output logic              in_flag,
    output logic              out_flag,
    output logic [CHAR_W-1:0] out_char,
    output logic              intr_cyc
);
    localparam int IND_BIT = DATA_W - 1;
    localparam int OPC_LSB = DATA_W - 4;
    localparam int PAD_W   = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    typedef struct packed {
        cpu_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] ac;
        logic              e;
        logic              ie;
        logic              fin;
        logic              fout;
        logic [CHAR_W-1:0] och;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic [2:0]        opc;
    logic              ind;
    logic              is_grp;
    logic [ADDR_W-1:0] pc_inc;
    logic [DATA_W-1:0] isz_sum;
    logic [DATA_W-1:0] g_ac;
    logic              g_e, g_skip, g_stop, g_take, g_put, g_ieon, g_ieoff;

    assign opc     = r_q.ir[OPC_LSB +: 3];
    assign ind     = r_q.ir[IND_BIT];
    assign is_grp  = (opc == OP_GRP);
    assign pc_inc  = r_q.pc + ONE_A;
    assign isz_sum = mem_rdata + DATA_W'(1);

    cpu_acc_grp #(
        .DATA_W(DATA_W),
        .CHAR_W(CHAR_W),
        .FLD_W (ADDR_W)
    ) u_grp (
        .io_sel  (ind),
        .fld     (r_q.ir[ADDR_W-1:0]),
        .ac      (r_q.ac),
        .e       (r_q.e),
        .in_char (in_char),
        .in_flag (r_q.fin),
        .out_flag(r_q.fout),
        .ac_n    (g_ac),
        .e_n     (g_e),
        .skip    (g_skip),
        .stop    (g_stop),
        .take_in (g_take),
        .put_out (g_put),
        .ie_on   (g_ieon),
        .ie_off  (g_ieoff)
    );

    // memory address depends on registered state only
    always_comb begin
        unique case (r_q.st)
            ST_DECODE: mem_addr = r_q.ir[ADDR_W-1:0];
            ST_EXEC:   mem_addr = r_q.ar;
            ST_INTR:   mem_addr = '0;
            default:   mem_addr = r_q.pc;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        intr_cyc  = 1'b0;
        unique case (r_q.st)
            ST_FETCH: begin
                r_d.ir = mem_rdata;
                r_d.pc = pc_inc;
                r_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.ar = (ind && !is_grp) ? mem_rdata[ADDR_W-1:0] : r_q.ir[ADDR_W-1:0];
                r_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                unique case (opc)
                    OP_AND: r_d.ac = r_q.ac & mem_rdata;
                    OP_ADD: {r_d.e, r_d.ac} = {1'b0, r_q.ac} + {1'b0, mem_rdata};
                    OP_LDA: r_d.ac = mem_rdata;
                    OP_STA: begin
                        mem_we    = 1'b1;
                        mem_wdata = r_q.ac;
                    end
                    OP_BUN: r_d.pc = r_q.ar;
                    OP_BSA: begin
                        mem_we    = 1'b1;
                        mem_wdata = {{PAD_W{1'b0}}, r_q.pc};
                        r_d.pc    = r_q.ar + ONE_A;
                    end
                    OP_ISZ: begin
                        mem_we    = 1'b1;
                        mem_wdata = isz_sum;
                        if (isz_sum == '0) r_d.pc = pc_inc;
                    end
                    default: begin
                        r_d.ac = g_ac;
                        r_d.e  = g_e;
                        if (g_skip)  r_d.pc = pc_inc;
                        if (g_take)  r_d.fin = 1'b0;
                        if (g_put) begin
                            r_d.fout = 1'b0;
                            r_d.och  = r_q.ac[CHAR_W-1:0];
                        end
                        if (g_ieon)  r_d.ie = 1'b1;
                        if (g_ieoff) r_d.ie = 1'b0;
                    end
                endcase
                if (is_grp && g_stop) begin
                    r_d.st = ST_HALT;
                end else if (r_d.ie && (r_d.fin || r_d.fout)) begin
                    r_d.st = ST_INTR;
                end else begin
                    r_d.st = ST_FETCH;
                end
            end
            ST_INTR: begin
                intr_cyc  = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {{PAD_W{1'b0}}, r_q.pc};
                r_d.pc    = ONE_A;
                r_d.ie    = 1'b0;
                r_d.st    = ST_FETCH;
            end
            default: r_d.st = ST_HALT;
        endcase
        if (in_strobe)  r_d.fin  = 1'b1;
        if (out_strobe) r_d.fout = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_FETCH;
            r_q.pc   <= RESET_PC;
            r_q.fout <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc       = r_q.pc;
    assign ac       = r_q.ac;
    assign e        = r_q.e;
    assign ie       = r_q.ie;
    assign halted   = (r_q.st == ST_HALT);
    assign in_flag  = r_q.fin;
    assign out_flag = r_q.fout;
    assign out_char = r_q.och;
endmodule

// File: rtl/cpu_acc.sv
module cpu_acc #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_strobe,
    input  logic              out_strobe,
    output logic [CHAR_W-1:0] out_char,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ac,
    output logic              e,
    output logic              halted,
    output logic              ie,
    output logic              in_flag,
    output logic              out_flag
);
    logic [ADDR_W-1:0] core_addr, m_addr;
    logic [DATA_W-1:0] core_wdata, m_wdata, m_rdata;
    logic              core_we, m_we;
    logic              intr_cyc;

    // load port owns memory only during reset
    assign m_addr  = rst_n ? core_addr  : ld_addr;
    assign m_wdata = rst_n ? core_wdata : ld_data;
    assign m_we    = rst_n ? core_we    : ld_en;

    cpu_acc_mem #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk  (clk),
        .we   (m_we),
        .addr (m_addr),
        .wdata(m_wdata),
        .rdata(m_rdata)
    );

    cpu_acc_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CHAR_W  (CHAR_W),
        .RESET_PC(ADDR_W'(16))
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_char   (in_char),
        .in_strobe (in_strobe),
        .out_strobe(out_strobe),
        .mem_rdata (m_rdata),
        .mem_addr  (core_addr),
        .mem_we    (core_we),
        .mem_wdata (core_wdata),
        .pc        (pc),
        .ac        (ac),
        .e         (e),
        .ie        (ie),
        .halted    (halted),
        .in_flag   (in_flag),
        .out_flag  (out_flag),
        .out_char  (out_char),
        .intr_cyc  (intr_cyc)
    );
endmodule

// File: rtl/cpu_acc_chk.sv
module cpu_acc_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic              ie,
    input logic              in_flag,
    input logic              out_flag,
    input logic              in_strobe,
    input logic              out_strobe,
    input logic              intr_cyc
);
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10
    AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc)); // R10
    AST_IN_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> in_flag); // R11
    AST_OUT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> out_flag); // R11
    AST_INTR_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        intr_cyc |-> ie && (in_flag || out_flag)); // R13
    AST_INTR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        intr_cyc |=> (pc == ADDR_W'(1)) && !ie); // R13
endmodule

bind cpu_acc cpu_acc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .pc        (pc),
    .ie        (ie),
    .in_flag   (in_flag),
    .out_flag  (out_flag),
    .in_strobe (in_strobe),
    .out_strobe(out_strobe),
    .intr_cyc  (intr_cyc)
);

// File: tb/tb_cpu_acc.sv
`timescale 1ns/1ps
module tb_cpu_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [7:0]  in_char = '0;
    logic        in_strobe = 1'b0;
    logic        out_strobe = 1'b0;
    logic [7:0]  out_char;
    logic [11:0] pc;
    logic [15:0] ac;
    logic        e, halted, ie, in_flag, out_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpu_acc dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .in_char(in_char), .in_strobe(in_strobe), .out_strobe(out_strobe),
        .out_char(out_char), .pc(pc), .ac(ac), .e(e), .halted(halted), .ie(ie),
        .in_flag(in_flag), .out_flag(out_flag)
    );

    // {req, pre_e, instr, ac0, operand, exp_ac, exp_e, exp_pc}
    localparam int NV = 24;
    localparam logic [91:0] VECS [NV] = '{
        92'h02_0_0101_F0F0_3C3C_3030_0_015, // R2 AND
        92'h02_0_1101_FFFF_0002_0001_1_015, // R2 ADD carry out
        92'h02_1_1101_0001_0002_0003_0_015, // R2 ADD rewrites E
        92'h02_1_2101_1234_ABCD_ABCD_1_015, // R2 LDA keeps E
        92'h02_1_0101_FFFF_00F0_00F0_1_015, // R2 AND keeps E
        92'h03_0_9102_0005_0007_000C_0_015, // R3 ADD indirect
        92'h03_1_A102_0000_BEEF_BEEF_1_015, // R3 LDA indirect
        92'h07_0_7800_5555_0000_0000_0_015, // R7 clear AC
        92'h07_1_7400_7777_0000_7777_0_015, // R7 clear E
        92'h07_1_7200_00FF_0000_FF00_1_015, // R7 invert AC
        92'h07_0_7100_1111_0000_1111_1_015, // R7 invert E
        92'h07_1_7020_FFFF_0000_0000_1_015, // R7 increment keeps E
        92'h08_1_7080_0003_0000_8001_1_015, // R8 rotate right
        92'h08_0_7040_8001_0000_0002_1_015, // R8 rotate left
        92'h09_0_7010_0001_0000_0001_0_016, // R9 positive skips
        92'h09_0_7010_0000_0000_0000_0_015, // R9 zero is not positive
        92'h09_0_7008_8000_0000_8000_0_016, // R9 negative skips
        92'h09_0_7008_7FFF_0000_7FFF_0_015, // R9 max positive not negative
        92'h09_0_7004_0000_0000_0000_0_016, // R9 zero skips
        92'h09_1_7002_0001_0000_0001_1_015, // R9 E set no skip
        92'h09_0_7002_0001_0000_0001_0_016, // R9 E clear skips
        92'h05_0_6101_0042_FFFF_0042_0_016, // R5 ISZ reaches zero
        92'h05_0_6101_0042_0005_0042_0_015, // R5 ISZ nonzero
        92'h06_0_4015_0042_0000_0042_0_016  // R6 BUN
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int lim);
        rst_n = 1'b1;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk({tag, " halt reached"}, 32'(halted), 32'd1);
    endtask

    task automatic pulse_in();
        in_strobe = 1'b1; @(negedge clk); in_strobe = 1'b0;
    endtask

    task automatic pulse_out();
        out_strobe = 1'b1; @(negedge clk); out_strobe = 1'b0;
    endtask

    initial begin : main
        logic [11:0] pc_hold;
        // R1 reset state
        hold_reset();
        chk("R1 pc", 32'(pc), 32'h010);
        chk("R1 ac", 32'(ac), 32'h0);
        chk("R1 e", 32'(e), 32'h0);
        chk("R1 halted", 32'(halted), 32'h0);
        chk("R1 ie", 32'(ie), 32'h0);
        chk("R1 in_flag", 32'(in_flag), 32'h0);
        chk("R1 out_flag", 32'(out_flag), 32'h1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i][91:84], i);
            hold_reset();
            put(12'h010, 16'h7400);
            put(12'h011, VECS[i][80] ? 16'h7100 : 16'h7000);
            put(12'h012, 16'h2100);
            put(12'h013, VECS[i][79:64]);
            put(12'h014, 16'h7001);
            put(12'h015, 16'h7001);
            put(12'h100, VECS[i][63:48]);
            put(12'h101, VECS[i][47:32]);
            put(12'h102, 16'h0101);
            run(tg, 100);
            chk({tg, " ac"}, 32'(ac), 32'(VECS[i][31:16]));
            chk({tg, " e"}, 32'(e), 32'(VECS[i][12]));
            chk({tg, " pc"}, 32'(pc), 32'(VECS[i][11:0]));
        end

        // R4 STA via indirect store (R3), then reload
        hold_reset();
        put(12'h010, 16'h2100); put(12'h011, 16'hB104); put(12'h012, 16'h7800);
        put(12'h013, 16'h2103); put(12'h014, 16'h7001);
        put(12'h100, 16'h5A5A); put(12'h103, 16'h0000); put(12'h104, 16'h0103);
        run("R4 sta", 100);
        chk("R4 sta reload ac", 32'(ac), 32'h5A5A);
        chk("R4 sta pc", 32'(pc), 32'h015);

        // R14 load-port write while running is ignored
        ld_en = 1'b1; ld_addr = 12'h103; ld_data = 16'hDEAD;
        @(negedge clk);
        ld_en = 1'b0;
        hold_reset();
        put(12'h010, 16'h2103); put(12'h011, 16'h7001);
        run("R14 ignore", 50);
        chk("R14 load ignored while running", 32'(ac), 32'h5A5A);

        // R4 BSA
        hold_reset();
        put(12'h010, 16'h5200); put(12'h011, 16'h7001);
        put(12'h200, 16'h0000); put(12'h201, 16'h2200); put(12'h202, 16'h7001);
        run("R4 bsa", 100);
        chk("R4 bsa return addr", 32'(ac), 32'h0011);
        chk("R4 bsa pc", 32'(pc), 32'h203);

        // R5 ISZ write-back
        hold_reset();
        put(12'h010, 16'h6101); put(12'h011, 16'h2101); put(12'h012, 16'h7001);
        put(12'h101, 16'h0007);
        run("R5 isz", 100);
        chk("R5 isz written back", 32'(ac), 32'h0008);

        // R9 PC wrap on skip, R10 frozen after halt
        hold_reset();
        put(12'h010, 16'h4FFF); put(12'hFFF, 16'h7004);
        put(12'h000, 16'h7800); put(12'h001, 16'h7001);
        run("R9 wrap", 100);
        chk("R9 wrap pc", 32'(pc), 32'h002);
        pc_hold = pc;
        repeat (20) @(negedge clk);
        chk("R10 pc frozen", 32'(pc), 32'(pc_hold));
        chk("R10 still halted", 32'(halted), 32'h1);

        // R11/R12 input poll, input, output
        hold_reset();
        put(12'h010, 16'hF200); put(12'h011, 16'h4010); put(12'h012, 16'hF800);
        put(12'h013, 16'hF100); put(12'h014, 16'h7001); put(12'h015, 16'hF400);
        put(12'h016, 16'h7001);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R12 no skip while input flag clear", 32'(halted), 32'h0);
        in_char = 8'hA5;
        pulse_in();
        chk("R11 strobe sets input flag", 32'(in_flag), 32'h1);
        run("R11 io", 100);
        chk("R11 ac from input", 32'(ac), 32'h00A5);
        chk("R11 out_char", 32'(out_char), 32'hA5);
        chk("R12 pc after SKO skip", 32'(pc), 32'h017);
        chk("R11 input flag cleared", 32'(in_flag), 32'h0);
        chk("R11 output flag cleared", 32'(out_flag), 32'h0);
        pulse_out();
        chk("R11 strobe sets output flag", 32'(out_flag), 32'h1);

        // R13 interrupt from idle loop
        hold_reset();
        put(12'h010, 16'hF400); put(12'h011, 16'hF080); put(12'h012, 16'h4012);
        put(12'h000, 16'h0000); put(12'h001, 16'h2000); put(12'h002, 16'h7001);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R13 idle not halted", 32'(halted), 32'h0);
        chk("R13 ie enabled", 32'(ie), 32'h1);
        pulse_out();
        run("R13 intr", 100);
        chk("R13 saved pc", 32'(ac), 32'h0012);
        chk("R13 ie cleared", 32'(ie), 32'h0);
        chk("R13 pc", 32'(pc), 32'h003);

        // R13 disable: no interrupt after IOF, none while halted
        hold_reset();
        put(12'h010, 16'hF400); put(12'h011, 16'hF080); put(12'h012, 16'hF040);
        put(12'h013, 16'h7001);
        run("R13 iof", 100);
        chk("R13 ie off", 32'(ie), 32'h0);
        pulse_in();
        repeat (5) @(negedge clk);
        chk("R13 no intr when disabled", 32'(pc), 32'h014);

        // R1 reset clears after a run
        hold_reset();
        chk("R1 reset clears ac", 32'(ac), 32'h0);
        chk("R1 reset clears halt", 32'(halted), 32'h0);

        done = 1'b1;
    end

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule